// File: doc/BRIEF.md
# IrDA Pipelined Mode Switcher

This block lets software stage the next infrared operating mode and baud divisor before the current transfer has finished. Software writes the staged mode and divisor into two pipeline registers and sets an arm bit. When the transmitter reports that it is empty, the block issues a one-cycle apply strobe. In that cycle it presents the staged values on its outputs so that the surrounding logic can copy them into its active registers. It also clears the arm bit by itself.

The switch is only allowed when automatic transceiver configuration is enabled and when both the present mode and the staged mode are IrDA modes. After every switch the block holds the transmitter off for a settling window so that the remote receive filter can stabilise. On a change from a fast mode (MIR or FIR) down to SIR, the window is stretched to one full character time at the new rate if that is longer. One character is ten bit periods, and each bit period is the divisor times the prescaler in input clocks.

Top module: `irpipe_switch`

## Requirements
- R1: After reset `armed`, `apply` and `tx_halt` are 0. While `apply` is 0, `new_mode` equals `cur_mode` and `new_div` equals `cur_div`.
- R2: `apply` is 1 for one cycle when all of the following hold: `armed` is 1, `tx_empty` is 1, `auto_xcvr_en` is 1, no halt is running, and both `cur_mode` and the staged mode are IrDA modes. In that cycle `new_mode` and `new_div` carry the staged values. Mode codes are 0 UART, 1 SIR, 2 MIR, 3 FIR, 4 amplitude-shift IR, and 5 to 7 reserved. Only 1, 2 and 3 count as IrDA.
- R3: After a switch `armed` reads 0 from the next cycle on, unless software writes the arm bit in the switch cycle.
- R4: With `auto_xcvr_en` at 0 no switch occurs and `armed` stays 1.
- R5: If either the present or the staged mode is not an IrDA mode, no switch occurs and `armed` stays 1.
- R6: For any switch that is not from MIR or FIR to SIR, `tx_halt` is 1 for exactly HALT_CLKS cycles, starting with the switch cycle.
- R7: For a switch from MIR or FIR to SIR, `tx_halt` lasts max(HALT_CLKS, 10 × PRESCALE × staged divisor) cycles, starting with the switch cycle.
- R8: While `tx_empty` is 0, no switch occurs.
- R9: A software arm write in the switch cycle wins over the self-clear, so `armed` stays 1. No new switch starts while a halt is running. The next switch fires in the first cycle after the halt ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pipe_mode_wr | input | 1 | Write strobe for the staged mode |
| pipe_mode_wdata | input | 3 | Staged mode code |
| pipe_div_wr | input | 1 | Write strobe for the staged divisor |
| pipe_div_wdata | input | DIV_W | Staged baud divisor |
| arm_wr | input | 1 | Write strobe for the arm bit |
| arm_wdata | input | 1 | Value written to the arm bit |
| tx_empty | input | 1 | Transmitter has nothing left to send |
| cur_mode | input | 3 | Mode currently active |
| cur_div | input | DIV_W | Divisor currently active |
| auto_xcvr_en | input | 1 | Automatic transceiver configuration enabled |
| new_mode | output | 3 | Mode to load: the staged mode during `apply`, otherwise `cur_mode` |
| new_div | output | DIV_W | Divisor to load: the staged divisor during `apply`, otherwise `cur_div` |
| apply | output | 1 | One-cycle switch strobe |
| tx_halt | output | 1 | Transmitter hold-off |
| armed | output | 1 | Present state of the arm bit |

## Verification
If the staged registers are corrupted, the wrong mode or divisor appears on `new_mode` or `new_div` in the very cycle of `apply`. A faulty arm bit shows one cycle after the switch, either through `armed` or through a second `apply` while `tx_empty` is still high. A wrong load value in the halt counter, or a wrong stretch decision, only shows at the falling edge of `tx_halt`, up to 10 × PRESCALE × (2^DIV_W − 1) cycles later. The bench therefore times every halt window to the exact cycle, for every pair of modes and for divisors on both sides of the crossover point.

// File: rtl/irpipe_pkg.sv
package irpipe_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_UART = 3'd0,
    MODE_SIR  = 3'd1,
    MODE_MIR  = 3'd2,
    MODE_FIR  = 3'd3,
    MODE_ASK  = 3'd4
  } ir_mode_e;

  function automatic logic mode_is_irda(logic [MODE_W-1:0] m);
    return (m == MODE_SIR) || (m == MODE_MIR) || (m == MODE_FIR);
  endfunction

  function automatic logic mode_is_fast(logic [MODE_W-1:0] m);
    return (m == MODE_MIR) || (m == MODE_FIR);
  endfunction
endpackage

// File: rtl/irpipe_regs.sv
module irpipe_regs
  import irpipe_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr_i,
  input  logic [MODE_W-1:0] mode_wdata_i,
  input  logic              div_wr_i,
  input  logic [DIV_W-1:0]  div_wdata_i,
  input  logic              arm_wr_i,
  input  logic              arm_wdata_i,
  input  logic              switch_i,
  output logic [MODE_W-1:0] pipe_mode_o,
  output logic [DIV_W-1:0]  pipe_div_o,
  output logic              armed_o
);
  logic [MODE_W-1:0] mode_q, mode_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic              arm_q, arm_d;

  always_comb begin
    mode_d = mode_wr_i ? mode_wdata_i : mode_q;
    div_d  = div_wr_i  ? div_wdata_i  : div_q;
    arm_d  = arm_q;
    if (switch_i) arm_d = 1'b0;
    if (arm_wr_i) arm_d = arm_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      div_q  <= '0;
      arm_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      div_q  <= div_d;
      arm_q  <= arm_d;
    end
  end

  assign pipe_mode_o = mode_q;
  assign pipe_div_o  = div_q;
  assign armed_o     = arm_q;

  p_arm_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (switch_i && !arm_wr_i) |=> !armed_o);
  p_arm_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_wr_i && arm_wdata_i) |=> armed_o);
endmodule

// File: rtl/irpipe_trigger.sv
module irpipe_trigger
  import irpipe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              armed_i,
  input  logic              tx_empty_i,
  input  logic              auto_en_i,
  input  logic              busy_i,
  input  logic [MODE_W-1:0] cur_mode_i,
  input  logic [MODE_W-1:0] pipe_mode_i,
  output logic              switch_o,
  output logic              stretch_o
);
  logic both_irda;

  always_comb begin
    both_irda = mode_is_irda(cur_mode_i) && mode_is_irda(pipe_mode_i);
    switch_o  = armed_i && tx_empty_i && auto_en_i && !busy_i && both_irda;
    stretch_o = mode_is_fast(cur_mode_i) && (pipe_mode_i == MODE_SIR);
  end

  p_no_auto_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en_i |-> !switch_o);
  p_not_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_empty_i |-> !switch_o);
endmodule

// File: rtl/irpipe_halt.sv
module irpipe_halt #(
  parameter int DIV_W     = 8,
  parameter int PRESCALE  = 13,
  parameter int HALT_CLKS = 12500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             stretch_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             busy_o
);
  localparam int BITS_PER_CHAR = 10;
  localparam int CHAR_MUL  = BITS_PER_CHAR * PRESCALE;
  localparam int MAX_CHAR  = CHAR_MUL * ((1 << DIV_W) - 1);
  localparam int MAX_LEN   = (MAX_CHAR > HALT_CLKS) ? MAX_CHAR : HALT_CLKS;
  localparam int CNT_W     = $clog2(MAX_LEN + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] char_clks, base_clks, len;

  always_comb begin
    char_clks = CNT_W'(CHAR_MUL) * CNT_W'(div_i);
    base_clks = CNT_W'(HALT_CLKS);
    len = (stretch_i && (char_clks > base_clks)) ? char_clks : base_clks;
    cnt_d = cnt_q;
    if (load_i)             cnt_d = len - 1'b1;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy_o = (cnt_q != '0);

  p_countdown_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
  p_no_load_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !load_i);
endmodule

// File: rtl/irpipe_switch.sv
module irpipe_switch
  import irpipe_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int PRESCALE  = 13,
  parameter int HALT_CLKS = 12500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pipe_mode_wr,
  input  logic [2:0]       pipe_mode_wdata,
  input  logic             pipe_div_wr,
  input  logic [DIV_W-1:0] pipe_div_wdata,
  input  logic             arm_wr,
  input  logic             arm_wdata,
  input  logic             tx_empty,
  input  logic [2:0]       cur_mode,
  input  logic [DIV_W-1:0] cur_div,
  input  logic             auto_xcvr_en,
  output logic [2:0]       new_mode,
  output logic [DIV_W-1:0] new_div,
  output logic             apply,
  output logic             tx_halt,
  output logic             armed
);
  logic [MODE_W-1:0] pipe_mode;
  logic [DIV_W-1:0]  pipe_div;
  logic              sw, stretch, busy;

  irpipe_regs #(.DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .mode_wr_i(pipe_mode_wr), .mode_wdata_i(pipe_mode_wdata),
    .div_wr_i(pipe_div_wr), .div_wdata_i(pipe_div_wdata),
    .arm_wr_i(arm_wr), .arm_wdata_i(arm_wdata),
    .switch_i(sw),
    .pipe_mode_o(pipe_mode), .pipe_div_o(pipe_div), .armed_o(armed)
  );

  irpipe_trigger u_trig (
    .clk(clk), .rst_n(rst_n),
    .armed_i(armed), .tx_empty_i(tx_empty), .auto_en_i(auto_xcvr_en),
    .busy_i(busy), .cur_mode_i(cur_mode), .pipe_mode_i(pipe_mode),
    .switch_o(sw), .stretch_o(stretch)
  );

  irpipe_halt #(.DIV_W(DIV_W), .PRESCALE(PRESCALE), .HALT_CLKS(HALT_CLKS)) u_halt (
    .clk(clk), .rst_n(rst_n),
    .load_i(sw), .stretch_i(stretch), .div_i(pipe_div),
    .busy_o(busy)
  );

  always_comb begin
    apply    = sw;
    tx_halt  = sw | busy;
    new_mode = sw ? pipe_mode : cur_mode;
    new_div  = sw ? pipe_div  : cur_div;
  end

  p_irda_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    apply |-> (mode_is_irda(cur_mode) && mode_is_irda(new_mode)));
  p_halt_starts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    apply |=> tx_halt || (HALT_CLKS == 1));
endmodule

// File: tb/irpipe_switch_bench.sv
module irpipe_switch_bench;
  localparam int DIV_W = 4;
  localparam int PRESCALE = 2;
  localparam int HALT_CLKS = 50;

  logic clk = 1'b0;
  logic rst_n;
  logic pipe_mode_wr, pipe_div_wr, arm_wr, arm_wdata, tx_empty, auto_xcvr_en;
  logic [2:0] pipe_mode_wdata, cur_mode, new_mode;
  logic [DIV_W-1:0] pipe_div_wdata, cur_div, new_div;
  logic apply, tx_halt, armed;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  irpipe_switch #(.DIV_W(DIV_W), .PRESCALE(PRESCALE), .HALT_CLKS(HALT_CLKS)) u_irpipe_switch (
    .clk(clk), .rst_n(rst_n),
    .pipe_mode_wr(pipe_mode_wr), .pipe_mode_wdata(pipe_mode_wdata),
    .pipe_div_wr(pipe_div_wr), .pipe_div_wdata(pipe_div_wdata),
    .arm_wr(arm_wr), .arm_wdata(arm_wdata),
    .tx_empty(tx_empty), .cur_mode(cur_mode), .cur_div(cur_div),
    .auto_xcvr_en(auto_xcvr_en),
    .new_mode(new_mode), .new_div(new_div), .apply(apply),
    .tx_halt(tx_halt), .armed(armed)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit is_irda(int m);
    return m >= 1 && m <= 3;
  endfunction

  function automatic int halt_len(int cm, int pm, int dv);
    int ch = 10 * PRESCALE * dv;
    if ((cm == 2 || cm == 3) && pm == 1 && ch > HALT_CLKS) return ch;
    return HALT_CLKS;
  endfunction

  task automatic stage(input int pm, input int dv);
    @(negedge clk);
    pipe_mode_wr = 1; pipe_mode_wdata = 3'(pm);
    pipe_div_wr = 1;  pipe_div_wdata = DIV_W'(dv);
    arm_wr = 1; arm_wdata = 1;
    @(negedge clk);
    pipe_mode_wr = 0; pipe_div_wr = 0; arm_wr = 0;
  endtask

  task automatic disarm();
    @(negedge clk);
    tx_empty = 0; arm_wr = 1; arm_wdata = 0;
    @(negedge clk);
    arm_wr = 0;
  endtask

  task automatic run_case(input int cm, input int pm, input int dv, input bit au);
    bit exp_sw;
    int n;
    cur_mode = 3'(cm); cur_div = DIV_W'(7); auto_xcvr_en = au; tx_empty = 0;
    stage(pm, dv);
    #1;
    chk(armed == 1, "R2 armed after write", armed, 1);
    chk(apply == 0, "R8 no switch while busy tx", apply, 0);
    @(negedge clk);
    tx_empty = 1;
    #1;
    exp_sw = au && is_irda(cm) && is_irda(pm);
    chk(apply == exp_sw, exp_sw ? "R2 apply" : (au ? "R5 blocked" : "R4 blocked"), apply, exp_sw);
    if (exp_sw) begin
      chk(new_mode == 3'(pm) && new_div == DIV_W'(dv), "R2 new values", int'(new_mode), pm);
      n = 0;
      while (tx_halt && n < 1000) begin
        n++;
        @(negedge clk); #1;
        if (apply) chk(0, "R3 second apply", 1, 0);
      end
      chk(n == halt_len(cm, pm, dv),
          (halt_len(cm, pm, dv) != HALT_CLKS || ((cm == 2 || cm == 3) && pm == 1)) ? "R7 halt len" : "R6 halt len",
          n, halt_len(cm, pm, dv));
      chk(armed == 0, "R3 self clear", armed, 0);
    end else begin
      chk(tx_halt == 0, "R5 no halt", tx_halt, 0);
      @(negedge clk); @(negedge clk); #1;
      chk(armed == 1 && apply == 0, au ? "R5 stays armed" : "R4 stays armed", armed, 1);
      chk(new_mode == 3'(cm), "R1 passthrough", int'(new_mode), cm);
    end
    disarm();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 0;
    pipe_mode_wr = 0; pipe_div_wr = 0; arm_wr = 0; arm_wdata = 0;
    pipe_mode_wdata = 0; pipe_div_wdata = 0;
    tx_empty = 1; cur_mode = 3'd1; cur_div = DIV_W'(9); auto_xcvr_en = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(armed == 0, "R1 armed", armed, 0);
    chk(apply == 0, "R1 apply", apply, 0);
    chk(tx_halt == 0, "R1 halt", tx_halt, 0);
    chk(new_mode == 3'd1 && new_div == DIV_W'(9), "R1 outputs", int'(new_div), 9);

    for (int cm = 0; cm < 8; cm++)
      for (int pm = 0; pm < 8; pm++)
        for (int k = 0; k < 3; k++)
          run_case(cm, pm, (k == 0) ? 1 : (k == 1) ? 3 : 15, 1'b1);
    for (int cm = 0; cm < 8; cm++)
      for (int pm = 0; pm < 8; pm++)
        run_case(cm, pm, 3, 1'b0);

    // R9: arm write in the switch cycle, no retrigger during halt
    begin
      int n;
      cur_mode = 3'd1; auto_xcvr_en = 1; tx_empty = 0;
      stage(3, 5);
      @(negedge clk);
      tx_empty = 1; arm_wr = 1; arm_wdata = 1;
      #1;
      chk(apply == 1, "R9 first apply", apply, 1);
      @(negedge clk);
      arm_wr = 0;
      #1;
      chk(armed == 1, "R9 arm write wins", armed, 1);
      chk(apply == 0, "R9 no retrigger", apply, 0);
      n = 1;
      while (!apply && n < 1000) begin
        @(negedge clk); #1;
        n++;
      end
      chk(n == HALT_CLKS, "R9 retrigger after halt", n, HALT_CLKS);
      disarm();
      repeat (HALT_CLKS + 2) @(negedge clk);
      #1;
      chk(tx_halt == 0, "R6 halt ends", tx_halt, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule